// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block resolves a virtual address into a physical address by walking translation tables held in main memory, as a memory management unit must after a miss in its translation cache. A walk starts with a 32-bit virtual address, a 4-bit context number, a pointer to the context table and the access kind (read, write or execute, in user or supervisor mode). The walker then fetches one 32-bit descriptor per level: context, region, segment and page. Each descriptor either points to the next table or ends the walk.

When the walk reaches a valid page entry that grants the access, the walker returns a 36-bit physical address and a cacheable flag. If the referenced or modified marks in that entry must change, it first stores the updated entry back to memory. If any level fails, it returns a fault code, the cause and the level at which the walk stopped. Memory traffic uses a single request/completion port with at most one transaction in flight.

Top module: `tablewalk_unit`

## Requirements
- R1: `reqReady` is high only while the walker is idle. A request is taken when `reqValid` and `reqReady` are both high. `reqValid` and the request fields have no effect while a walk is in progress.
- R2: The two low bits of every descriptor are a type tag: 0 invalid, 1 pointer to the next table, 2 terminal page entry, 3 reserved.
- R3: The context descriptor is read at `{ctxTablePtr, 6'b0} + 4*reqCtx`. A pointer descriptor `d` gives a next table base of `{d[31:2], 6'b0}`, to which 4 times the next index is added. The region index is va[31:24], the segment index is va[23:18] and the page index is va[17:12].
- R4: At levels 0 (context), 1 (region) and 2 (segment), any tag other than a pointer ends the walk with `doneFault` = 1 and `faultLevel` set to that level. `faultCause` is 2 for tag 3 and 1 for tags 0 and 2.
- R5: At level 3 (page), any tag other than a page entry faults with `faultLevel` = 3. `faultCause` is 2 for tag 3 and 1 for tags 0 and 1.
- R6: Page entry permission field bits 4:2 hold a code meaning user/supervisor rights: 0 R/R, 1 RW/RW, 2 RX/RX, 3 RWX/RWX, 4 X/X, 5 R/RW, 6 none/RX, 7 none/RWX. A user access with code 6 or 7 is a protection fault (`faultCause` = 3, level 3).
- R7: A write, an execute or a read is permitted only if the code grants that right in the current mode; otherwise it is a protection fault (cause 3, level 3).
- R8: On success `donePa` = {entry[31:8], va[11:0]}, `doneCacheable` = entry bit 7 and `doneFault` = 0.
- R9: On success the entry is stored back to the same address with bit 5 (referenced) set, and with bit 6 (modified) also set for a write. The store is issued only when this changes the entry. A fault stores nothing.
- R10: A walk issues exactly one memory read per level reached. `memReq`, `memWrite` and `memAddr` stay steady from the start of a transaction until its `memDone`.
- R11: After reset `reqReady` = 1, `memReq` = 0 and `doneValid` = 0. `doneValid` pulses for one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Walk request |
| reqReady | output | 1 | Walker idle, request can be taken |
| reqVa | input | 32 | Virtual address |
| reqCtx | input | 4 | Context number |
| ctxTablePtr | input | 30 | Context table base, physical bits 35:6 |
| reqWrite | input | 1 | Access is a write |
| reqExec | input | 1 | Access is an instruction fetch |
| reqUser | input | 1 | Access is in user mode |
| memReq | output | 1 | Memory transaction request |
| memWrite | output | 1 | Transaction is a store |
| memAddr | output | 36 | Physical word address |
| memWData | output | 32 | Store data |
| memDone | input | 1 | Transaction complete; read data valid |
| memRData | input | 32 | Read data |
| doneValid | output | 1 | Walk result valid (one cycle) |
| donePa | output | 36 | Physical address |
| doneCacheable | output | 1 | Access may be cached |
| doneFault | output | 1 | Walk ended in a fault |
| faultLevel | output | 2 | Level at which the walk stopped |
| faultCause | output | 2 | 0 none, 1 invalid, 2 reserved, 3 protection |

## Verification
The assertions rely on the memory side answering each transaction with exactly one `memDone` pulse, and only while `memReq` is high. They also assume that read data is valid in the same cycle as that pulse. The bench responder raises `memDone` for one cycle, one clock after it sees an unanswered request, and never at any other time. Execute and write are never requested together. Requests are held only until accepted, except in the one scenario that keeps `reqValid` high during a walk on purpose.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int VA_W   = 32;
  localparam int PA_W   = 36;
  localparam int CTX_W  = 4;
  localparam int ENT_W  = 32;
  localparam int PGOFF_W = 12;
  localparam int PTR_W  = PA_W - 6;

  typedef enum logic [1:0] {
    TAG_INVALID = 2'd0,
    TAG_PTD     = 2'd1,
    TAG_PTE     = 2'd2,
    TAG_RSVD    = 2'd3
  } tw_tag_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_INVAL = 2'd1,
    CAUSE_RSVD  = 2'd2,
    CAUSE_PROT  = 2'd3
  } tw_cause_e;

  typedef struct packed {
    logic startWalk;
    logic captureEntry;
    logic advance;
    logic recordFault;
    logic recordHit;
  } tw_strobe_t;

  typedef struct packed {
    logic isPtd;
    logic isPte;
    logic lastLevel;
    logic permOk;
    logic needWb;
  } tw_status_t;

  // Rights granted by a 3-bit code for the given mode and access kind.
  function automatic logic tw_permits(input logic [2:0] code, input logic user,
                                      input logic wr, input logic ex);
    logic rdOk, wrOk, exOk;
    if (user) begin
      rdOk = (code == 3'd0) || (code == 3'd1) || (code == 3'd2) ||
             (code == 3'd3) || (code == 3'd5);
      wrOk = (code == 3'd1) || (code == 3'd3);
      exOk = (code == 3'd2) || (code == 3'd3) || (code == 3'd4);
    end else begin
      rdOk = (code != 3'd4);
      wrOk = code[0];
      exOk = (code == 3'd2) || (code == 3'd3) || (code == 3'd4) ||
             (code == 3'd6) || (code == 3'd7);
    end
    if (wr)      return wrOk;
    else if (ex) return exOk;
    else         return rdOk;
  endfunction
endpackage

// File: rtl/tw_ctrl.sv
module tw_ctrl
  import tw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  input  logic       memDone,
  output logic       memReq,
  output logic       memWrite,
  output logic       doneValid,
  input  tw_status_t status,
  output tw_strobe_t strobe
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_EVAL, ST_WB, ST_DONE
  } tw_state_e;

  tw_state_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD   = stateQ;
    strobe   = '0;
    memReq   = 1'b0;
    memWrite = 1'b0;
    doneValid = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.startWalk = 1'b1;
          stateD = ST_READ;
        end
      end
      ST_READ: begin
        memReq = 1'b1;
        if (memDone) begin
          strobe.captureEntry = 1'b1;
          stateD = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (!status.lastLevel) begin
          if (status.isPtd) begin
            strobe.advance = 1'b1;
            stateD = ST_READ;
          end else begin
            strobe.recordFault = 1'b1;
            stateD = ST_DONE;
          end
        end else if (status.isPte && status.permOk) begin
          strobe.recordHit = 1'b1;
          stateD = status.needWb ? ST_WB : ST_DONE;
        end else begin
          strobe.recordFault = 1'b1;
          stateD = ST_DONE;
        end
      end
      ST_WB: begin
        memReq   = 1'b1;
        memWrite = 1'b1;
        if (memDone) stateD = ST_DONE;
      end
      ST_DONE: begin
        doneValid = 1'b1;
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign reqReady = (stateQ == ST_IDLE);
endmodule

// File: rtl/tw_dpath.sv
module tw_dpath
  import tw_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  tw_strobe_t         strobe,
  output tw_status_t         status,
  input  logic [VA_W-1:0]    reqVa,
  input  logic [CTX_W-1:0]   reqCtx,
  input  logic [PTR_W-1:0]   ctxTablePtr,
  input  logic               reqWrite,
  input  logic               reqExec,
  input  logic               reqUser,
  input  logic [ENT_W-1:0]   memRData,
  output logic [PA_W-1:0]    memAddr,
  output logic [ENT_W-1:0]   memWData,
  output logic [PA_W-1:0]    donePa,
  output logic               doneCacheable,
  output logic               doneFault,
  output logic [1:0]         faultLevel,
  output logic [1:0]         faultCause
);
  localparam int IDX_W  = 10;
  localparam int PPN_W  = PA_W - PGOFF_W;
  localparam int BIT_C  = 7;
  localparam int BIT_M  = 6;
  localparam int BIT_R  = 5;

  logic [VA_W-1:0]  vaQ;
  logic             wrQ, exQ, usQ;
  logic [1:0]       levelQ;
  logic [PA_W-1:0]  addrQ;
  logic [ENT_W-1:0] entryQ;

  logic [PA_W-1:0]  resPaQ;
  logic             resCacheQ, resFaultQ;
  logic [1:0]       resLevelQ;
  tw_cause_e        resCauseQ;

  tw_tag_e          tag;
  logic [IDX_W-1:0] idxScaled;
  logic [PA_W-1:0]  ctxAddr, nextAddr;
  logic [ENT_W-1:0] markedEntry;
  tw_cause_e        faultWhy;

  assign tag = tw_tag_e'(entryQ[1:0]);

  // Scaled index for the table reached after the current level.
  always_comb begin
    unique case (levelQ)
      2'd0:    idxScaled = {vaQ[31:24], 2'b00};
      2'd1:    idxScaled = {2'b00, vaQ[23:18], 2'b00};
      default: idxScaled = {2'b00, vaQ[17:12], 2'b00};
    endcase
  end

  assign ctxAddr  = {ctxTablePtr, 6'b0} + {{(PA_W-CTX_W-2){1'b0}}, reqCtx, 2'b00};
  assign nextAddr = {entryQ[ENT_W-1:2], 6'b0} + {{(PA_W-IDX_W){1'b0}}, idxScaled};

  always_comb begin
    markedEntry = entryQ;
    markedEntry[BIT_R] = 1'b1;
    if (wrQ) markedEntry[BIT_M] = 1'b1;
  end

  always_comb begin
    if (tag == TAG_RSVD)                       faultWhy = CAUSE_RSVD;
    else if (levelQ == 2'd3 && tag == TAG_PTE) faultWhy = CAUSE_PROT;
    else                                       faultWhy = CAUSE_INVAL;
  end

  assign status.isPtd     = (tag == TAG_PTD);
  assign status.isPte     = (tag == TAG_PTE);
  assign status.lastLevel = (levelQ == 2'd3);
  assign status.permOk    = tw_permits(entryQ[4:2], usQ, wrQ, exQ);
  assign status.needWb    = (markedEntry != entryQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaQ    <= '0;
      wrQ    <= 1'b0;
      exQ    <= 1'b0;
      usQ    <= 1'b0;
      levelQ <= '0;
      addrQ  <= '0;
      entryQ <= '0;
    end else begin
      if (strobe.startWalk) begin
        vaQ    <= reqVa;
        wrQ    <= reqWrite;
        exQ    <= reqExec;
        usQ    <= reqUser;
        levelQ <= 2'd0;
        addrQ  <= ctxAddr;
      end
      if (strobe.captureEntry) entryQ <= memRData;
      if (strobe.advance) begin
        levelQ <= levelQ + 2'd1;
        addrQ  <= nextAddr;
      end
      if (strobe.recordHit) entryQ <= markedEntry;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resPaQ    <= '0;
      resCacheQ <= 1'b0;
      resFaultQ <= 1'b0;
      resLevelQ <= '0;
      resCauseQ <= CAUSE_NONE;
    end else if (strobe.recordHit) begin
      resPaQ    <= {entryQ[ENT_W-1:ENT_W-PPN_W], vaQ[PGOFF_W-1:0]};
      resCacheQ <= entryQ[BIT_C];
      resFaultQ <= 1'b0;
      resLevelQ <= levelQ;
      resCauseQ <= CAUSE_NONE;
    end else if (strobe.recordFault) begin
      resCacheQ <= 1'b0;
      resFaultQ <= 1'b1;
      resLevelQ <= levelQ;
      resCauseQ <= faultWhy;
    end
  end

  assign memAddr       = addrQ;
  assign memWData      = entryQ;
  assign donePa        = resPaQ;
  assign doneCacheable = resCacheQ;
  assign doneFault     = resFaultQ;
  assign faultLevel    = resLevelQ;
  assign faultCause    = resCauseQ;

  // R4: a fault before the page level never reports a protection cause
  assert_upper_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.recordFault && levelQ != 2'd3 |=> faultCause != CAUSE_PROT);
endmodule

// File: rtl/tablewalk_unit.sv
module tablewalk_unit
  import tw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [31:0] reqVa,
  input  logic [3:0]  reqCtx,
  input  logic [29:0] ctxTablePtr,
  input  logic        reqWrite,
  input  logic        reqExec,
  input  logic        reqUser,
  output logic        memReq,
  output logic        memWrite,
  output logic [35:0] memAddr,
  output logic [31:0] memWData,
  input  logic        memDone,
  input  logic [31:0] memRData,
  output logic        doneValid,
  output logic [35:0] donePa,
  output logic        doneCacheable,
  output logic        doneFault,
  output logic [1:0]  faultLevel,
  output logic [1:0]  faultCause
);
  tw_strobe_t strobe;
  tw_status_t status;

  tw_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .memDone(memDone), .memReq(memReq), .memWrite(memWrite),
    .doneValid(doneValid), .status(status), .strobe(strobe)
  );

  tw_dpath dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .status(status),
    .reqVa(reqVa), .reqCtx(reqCtx), .ctxTablePtr(ctxTablePtr),
    .reqWrite(reqWrite), .reqExec(reqExec), .reqUser(reqUser),
    .memRData(memRData), .memAddr(memAddr), .memWData(memWData),
    .donePa(donePa), .doneCacheable(doneCacheable), .doneFault(doneFault),
    .faultLevel(faultLevel), .faultCause(faultCause)
  );

  assert_ready_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memReq && !doneValid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memDone |=> memReq && $stable(memWrite) && $stable(memAddr));

  assert_prot_level_R6: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && doneFault && faultCause == 2'd3 |-> faultLevel == 2'd3);

  assert_wb_marks_R9: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWrite |-> memWData[5] && memWData[1:0] == 2'd2);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);
endmodule

// File: tb/tablewalk_unit_tb_top.sv
module tablewalk_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVa = '0;
  logic [3:0]  reqCtx = '0;
  logic [29:0] ctxTablePtr = 30'h400;   // table at physical 0x10000
  logic        reqWrite = 1'b0, reqExec = 1'b0, reqUser = 1'b0;
  logic        memReq, memWrite;
  logic [35:0] memAddr;
  logic [31:0] memWData;
  logic        memDone = 1'b0;
  logic [31:0] memRData = '0;
  logic        doneValid, doneCacheable, doneFault;
  logic [35:0] donePa;
  logic [1:0]  faultLevel, faultCause;

  int vectors = 0;
  int miscompares = 0;
  int rdCount = 0;
  int wbCount = 0;
  logic [35:0] lastWbAddr = '0;
  logic [31:0] memArr [logic [35:0]];

  localparam logic [35:0] REG_BASE = 36'h20000;
  localparam logic [35:0] SEG_BASE = 36'h30000;
  localparam logic [35:0] PG_BASE  = 36'h40000;

  always #10 clk = ~clk;

  tablewalk_unit dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVa(reqVa), .reqCtx(reqCtx), .ctxTablePtr(ctxTablePtr),
    .reqWrite(reqWrite), .reqExec(reqExec), .reqUser(reqUser),
    .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr),
    .memWData(memWData), .memDone(memDone), .memRData(memRData),
    .doneValid(doneValid), .donePa(donePa), .doneCacheable(doneCacheable),
    .doneFault(doneFault), .faultLevel(faultLevel), .faultCause(faultCause)
  );

  function automatic logic [31:0] memRd(input logic [35:0] a);
    return memArr.exists(a) ? memArr[a] : 32'h0;
  endfunction

  function automatic logic [31:0] ptd(input logic [35:0] base);
    return base[35:4] | 32'h1;
  endfunction

  // Memory responder: one completion pulse per request, one cycle later.
  initial begin
    forever begin
      @(posedge clk);
      if (memReq && !memDone) begin
        memDone <= 1'b1;
        if (memWrite) begin
          memArr[memAddr] = memWData;
          lastWbAddr <= memAddr;
          wbCount++;
        end else begin
          memRData <= memRd(memAddr);
          rdCount++;
        end
      end else begin
        memDone <= 1'b0;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] ctxA(input logic [3:0] c);
    return 36'h10000 + {30'b0, c, 2'b00};
  endfunction
  function automatic logic [35:0] regA(input logic [31:0] va);
    return REG_BASE + {26'b0, va[31:24], 2'b00};
  endfunction
  function automatic logic [35:0] segA(input logic [31:0] va);
    return SEG_BASE + {28'b0, va[23:18], 2'b00};
  endfunction
  function automatic logic [35:0] pgA(input logic [31:0] va);
    return PG_BASE + {28'b0, va[17:12], 2'b00};
  endfunction

  task automatic buildPath(input logic [3:0] c, input logic [31:0] va,
                           input logic [31:0] eCtx, input logic [31:0] eReg,
                           input logic [31:0] eSeg, input logic [31:0] ePg);
    memArr[ctxA(c)] = eCtx;
    memArr[regA(va)] = eReg;
    memArr[segA(va)] = eSeg;
    memArr[pgA(va)] = ePg;
  endtask

  task automatic goodPath(input logic [3:0] c, input logic [31:0] va, input logic [31:0] ePg);
    buildPath(c, va, ptd(REG_BASE), ptd(SEG_BASE), ptd(PG_BASE), ePg);
  endtask

  // Runs one walk; returns with outputs sampled at the negedge where doneValid is high.
  task automatic doWalk(input logic [31:0] va, input logic [3:0] c,
                        input logic wr, input logic ex, input logic us,
                        output int rdD, output int wbD);
    int rd0, wb0, cyc;
    while (reqReady !== 1'b1) @(negedge clk);
    rd0 = rdCount; wb0 = wbCount;
    reqVa = va; reqCtx = c; reqWrite = wr; reqExec = ex; reqUser = us;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    cyc = 0;
    while (doneValid !== 1'b1 && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    if (cyc >= 200) chk("R11 walk timeout", 0, 1);
    rdD = rdCount - rd0;
    wbD = wbCount - wb0;
  endtask

  task automatic tReset;
    chk("R11 reset reqReady", reqReady, 1);
    chk("R11 reset memReq", memReq, 0);
    chk("R11 reset doneValid", doneValid, 0);
  endtask

  task automatic tSupReadHit;
    int rdD, wbD;
    logic [31:0] va = 32'h12345678;
    goodPath(4'd3, va, 32'hABCDE182);   // C=1, code 0, tag 2
    doWalk(va, 4'd3, 0, 0, 0, rdD, wbD);
    chk("R8 hit no fault", doneFault, 0);
    chk("R8 physical address", donePa, 36'hABCDE1678);
    chk("R8 cacheable set", doneCacheable, 1);
    chk("R10 four reads", rdD, 4);
    chk("R9 one write-back", wbD, 1);
    chk("R3 write-back address", lastWbAddr, pgA(va));
    chk("R9 referenced set", memRd(pgA(va)), 32'hABCDE1A2);
    @(negedge clk);
    chk("R11 done one cycle", doneValid, 0);
  endtask

  task automatic tUserWriteHit;
    int rdD, wbD;
    logic [31:0] va = 32'hFF0C2ABC;
    goodPath(4'd5, va, 32'h00012306);   // C=0, code 1 RW/RW
    doWalk(va, 4'd5, 1, 0, 1, rdD, wbD);
    chk("R7 user write code 1", doneFault, 0);
    chk("R8 physical address", donePa, 36'h000123ABC);
    chk("R8 non-cacheable", doneCacheable, 0);
    chk("R9 referenced and modified", memRd(pgA(va)), 32'h00012366);
  endtask

  task automatic tMarkedNoWb;
    int rdD, wbD;
    logic [31:0] va = 32'h12345678;
    goodPath(4'd3, va, 32'hABCDE1A2);   // referenced already set
    doWalk(va, 4'd3, 0, 0, 0, rdD, wbD);
    chk("R9 no write-back when unchanged", wbD, 0);
    chk("R8 physical address", donePa, 36'hABCDE1678);
  endtask

  task automatic tUserProt;
    int rdD, wbD;
    logic [31:0] va = 32'h00841000;
    goodPath(4'd1, va, 32'h5555551A);   // code 6 none/RX
    doWalk(va, 4'd1, 0, 0, 1, rdD, wbD);
    chk("R6 user code 6 faults", doneFault, 1);
    chk("R6 fault level", faultLevel, 3);
    chk("R6 fault cause", faultCause, 3);
    chk("R9 no write-back on fault", wbD, 0);
    chk("R9 entry untouched", memRd(pgA(va)), 32'h5555551A);
    goodPath(4'd1, va, 32'h55555516);   // code 5 R/RW
    doWalk(va, 4'd1, 1, 0, 1, rdD, wbD);
    chk("R7 user write code 5", faultCause, 3);
  endtask

  task automatic tSupRights;
    int rdD, wbD;
    logic [31:0] va = 32'h40FC3004;
    goodPath(4'd0, va, 32'h00077702);   // code 0 R/R
    doWalk(va, 4'd0, 1, 0, 0, rdD, wbD);
    chk("R7 sup write code 0", {doneFault, faultCause}, {1'b1, 2'd3});
    goodPath(4'd0, va, 32'h00077716);   // code 5 R/RW
    doWalk(va, 4'd0, 1, 0, 0, rdD, wbD);
    chk("R7 sup write code 5", doneFault, 0);
    chk("R9 modified set", memRd(pgA(va)), 32'h00077776);
    goodPath(4'd0, va, 32'h00077716);
    doWalk(va, 4'd0, 0, 1, 0, rdD, wbD);
    chk("R7 sup exec code 5", {doneFault, faultCause}, {1'b1, 2'd3});
    goodPath(4'd0, va, 32'h00077712);   // code 4 X/X
    doWalk(va, 4'd0, 0, 1, 1, rdD, wbD);
    chk("R7 user exec code 4", doneFault, 0);
    doWalk(va, 4'd0, 0, 0, 0, rdD, wbD);
    chk("R7 sup read code 4", {doneFault, faultCause}, {1'b1, 2'd3});
  endtask

  task automatic tUpperFaults;
    int rdD, wbD;
    logic [31:0] va = 32'h7F8C5000;
    buildPath(4'd9, va, 32'h0, ptd(SEG_BASE), ptd(PG_BASE), 32'h00000202);
    doWalk(va, 4'd9, 0, 0, 0, rdD, wbD);
    chk("R4 context invalid", {doneFault, faultLevel, faultCause}, {1'b1, 2'd0, 2'd1});
    chk("R10 one read", rdD, 1);
    buildPath(4'd9, va, ptd(REG_BASE), 32'h3, ptd(PG_BASE), 32'h00000202);
    doWalk(va, 4'd9, 0, 0, 0, rdD, wbD);
    chk("R4 region reserved", {doneFault, faultLevel, faultCause}, {1'b1, 2'd1, 2'd2});
    chk("R10 two reads", rdD, 2);
    buildPath(4'd9, va, ptd(REG_BASE), ptd(SEG_BASE), 32'h00000302, 32'h00000202);
    doWalk(va, 4'd9, 0, 0, 0, rdD, wbD);
    chk("R4 segment terminal", {doneFault, faultLevel, faultCause}, {1'b1, 2'd2, 2'd1});
    chk("R10 three reads", rdD, 3);
  endtask

  task automatic tPageType;
    int rdD, wbD;
    logic [31:0] va = 32'hC0013000;
    goodPath(4'd2, va, ptd(PG_BASE));
    doWalk(va, 4'd2, 0, 0, 0, rdD, wbD);
    chk("R5 page pointer tag", {doneFault, faultLevel, faultCause}, {1'b1, 2'd3, 2'd1});
    goodPath(4'd2, va, 32'h00000283);
    doWalk(va, 4'd2, 0, 0, 0, rdD, wbD);
    chk("R5 page reserved tag", {doneFault, faultLevel, faultCause}, {1'b1, 2'd3, 2'd2});
    goodPath(4'd2, va, 32'h00000280);
    doWalk(va, 4'd2, 0, 0, 0, rdD, wbD);
    chk("R2 tag 0 invalid", {doneFault, faultCause}, {1'b1, 2'd1});
  endtask

  task automatic tBusyIgnored;
    int rd0, cyc;
    logic [31:0] va1 = 32'h0A1B2345;
    logic [31:0] va2 = 32'hF0F0F999;
    goodPath(4'd4, va1, 32'h0000AB82);
    goodPath(4'd4, va2, 32'h0000CD82);
    while (reqReady !== 1'b1) @(negedge clk);
    rd0 = rdCount;
    reqVa = va1; reqCtx = 4'd4; reqWrite = 0; reqExec = 0; reqUser = 0;
    reqValid = 1'b1;
    @(negedge clk);
    reqVa = va2;                       // held request while busy
    chk("R1 busy not ready", reqReady, 0);
    repeat (3) @(negedge clk);
    reqValid = 1'b0;
    cyc = 0;
    while (doneValid !== 1'b1 && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    chk("R1 first request result", donePa, 36'h0000AB345);
    chk("R1 single walk reads", rdCount - rd0, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tSupReadHit();
    tUserWriteHit();
    tMarkedNoWb();
    tUserProt();
    tSupRights();
    tUpperFaults();
    tPageType();
    tBusyIgnored();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule